// File: doc/BRIEF.md
# Interrupt Acceptance Gating Unit

This unit sits beside the retire stage of a processor core and decides, at every instruction boundary, whether an external event may be taken there. It tracks the maskable-interrupt enable flag, whether the non-maskable handler is running, a single latched non-maskable request, and the stack-switch shadow. A boundary is signalled by a one-cycle retire strobe; the decode flags of the instruction that retires travel with that strobe.

Three events compete at each boundary: a single-step trap, a non-maskable interrupt (NMI) and a maskable interrupt. At most one of them wins. The winner is reported one clock later as a one-cycle pulse, together with the vector to use. NMIs arrive either as a rising edge on an asynchronous pin or as a strobe from the message path. While the NMI handler is running, further arrivals collapse into one pending request. That request is delivered at the boundary that releases the block. A separate pulse reports an attempt to change the enable flag at insufficient privilege.

The effects of the retiring instruction on the enable flag and on NMI blocking apply to the same boundary that the instruction closes.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset the enable flag is clear, no NMI is pending or blocked, and take_step, take_nmi, take_intr, gp_fault and acc_vector are all zero.
- R2: Accept outputs change only in the clock after a cycle with retire high, last exactly one cycle, and at most one of take_step, take_nmi and take_intr is high at a time; acc_vector is 0 when none is high.
- R3: A rising edge on nmi_pin, taken through a two-flop synchronizer, or a one-cycle nmi_msg strobe creates an NMI request. The request is accepted regardless of the enable flag and reported with acc_vector equal to 2.
- R4: Once an NMI is accepted, no further NMI is accepted until a boundary whose retiring instruction has is_iret or is_iret_fault set. That releasing boundary may itself accept a pending NMI.
- R5: Any number of NMI arrivals while NMIs are blocked produce exactly one NMI after the release.
- R6: A boundary with intr_req high accepts the maskable interrupt only if the enable flag, after the retiring instruction's effect, is set. It is reported with acc_vector equal to intr_vec.
- R7: is_sti sets the enable flag and is_cli clears it only when cpl <= iopl (unsigned). Otherwise gp_fault pulses in the next cycle and the flag keeps its value.
- R8: is_int_gate clears the enable flag. is_trap_gate leaves it unchanged. When both are set the flag is unchanged.
- R9: A boundary whose retiring instruction has is_ss_load set accepts nothing: no step trap, no NMI, no maskable interrupt. The following boundary is evaluated normally.
- R10: Priority is step trap (acc_vector 1), then NMI, then maskable interrupt. A losing NMI stays pending, and a losing maskable request is taken later if intr_req is still high.
- R11: Enable-flag changes and NMI release from the retiring instruction apply at the boundary that the instruction closes. If STI and an interrupt-gate flag come together, the gate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous NMI pin, rising edge triggered |
| nmi_msg | input | 1 | One-cycle NMI message strobe |
| intr_req | input | 1 | Maskable interrupt request level |
| intr_vec | input | 8 | Vector of the maskable request |
| step_req | input | 1 | Single-step/debug trap pending on the retiring instruction |
| retire | input | 1 | Instruction boundary strobe |
| is_iret | input | 1 | Retiring instruction is an interrupt return |
| is_iret_fault | input | 1 | Retiring interrupt return raised a protection fault |
| is_sti | input | 1 | Retiring instruction sets the enable flag |
| is_cli | input | 1 | Retiring instruction clears the enable flag |
| is_ss_load | input | 1 | Retiring instruction loaded the stack segment |
| is_int_gate | input | 1 | Handler entry through an interrupt gate |
| is_trap_gate | input | 1 | Handler entry through a trap gate |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| take_step | output | 1 | Step trap accepted (pulse) |
| take_nmi | output | 1 | NMI accepted (pulse) |
| take_intr | output | 1 | Maskable interrupt accepted (pulse) |
| acc_vector | output | 8 | Vector of the accepted event |
| gp_fault | output | 1 | Privilege fault on an enable-flag change (pulse) |

## Verification
Several functions can land on the same boundary. An interrupt return that releases NMI blocking can coincide with a merged pending NMI, which must then be taken at that very boundary. An STI or an interrupt-gate entry can coincide with a live maskable request, and its new flag value decides whether the request is taken. The bench provokes these by driving the flags together with the requests on a single retire strobe. It sweeps every combination of shadow, step, NMI arrival, maskable request and prior flag value, and judges each boundary against a model of the flag, block and pending state.

// File: rtl/irq_gate_pkg.sv
// Shared constants and types for the interrupt acceptance gating unit.
// Assumes 8-bit vectors and 2-bit privilege levels.
package irq_gate_pkg;
    localparam int VEC_W       = 8;
    localparam int PL_W        = 2;
    localparam int SYNC_STAGES = 2;
    localparam logic [VEC_W-1:0] STEP_VEC = 8'd1;
    localparam logic [VEC_W-1:0] NMI_VEC  = 8'd2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STEP = 2'd1,
        SEL_NMI  = 2'd2,
        SEL_INTR = 2'd3
    } sel_e;
endpackage

// File: rtl/irq_pin_edge.sv
// Synchronizes an asynchronous pin through STAGES flops and flags a rising
// edge for one cycle. Assumes the pin is held low during reset.
module irq_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], pin};
    end

    // Rising edge of the synchronized value.
    always_comb rise = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/irq_nmi_track.sv
// Holds the single pending NMI bit and the NMI-blocked bit. New arrivals
// merge into the pending bit; a release input unblocks in the same cycle.
module irq_nmi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic release_i,
    input  logic accept,
    output logic pend_eff,
    output logic blk_eff,
    output logic blk_q
);
    logic pend_q;

    // Effective state seen by the selector at this boundary.
    always_comb begin
        pend_eff = pend_q | arrive;
        blk_eff  = blk_q & ~release_i;
    end

    // Update pending and blocked bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            blk_q  <= 1'b0;
        end else begin
            pend_q <= pend_eff & ~accept;
            blk_q  <= blk_eff | accept;
        end
    end
endmodule

// File: rtl/irq_if_ctrl.sv
// Keeps the maskable-interrupt enable flag. Applies privileged set/clear and
// gate-entry effects at a retire boundary and reports privilege faults.
module irq_if_ctrl
    import irq_gate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire,
    input  logic            sti,
    input  logic            cli,
    input  logic            int_gate,
    input  logic            trap_gate,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            if_eff,
    output logic            if_q,
    output logic            priv_fault
);
    logic priv_ok;

    // Flag value after the retiring instruction's effect.
    always_comb begin
        priv_ok    = (cpl <= iopl);
        priv_fault = retire & (sti | cli) & ~priv_ok;
        if_eff     = if_q;
        if (retire) begin
            if (sti && priv_ok) if_eff = 1'b1;
            if (cli && priv_ok) if_eff = 1'b0;
            if (int_gate && !trap_gate) if_eff = 1'b0;
        end
    end

    // Store the flag; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) if_q <= 1'b0;
        else        if_q <= if_eff;
    end
endmodule

// File: rtl/irq_select.sv
// Fixed-priority choice among step trap, NMI and maskable interrupt at one
// boundary; the stack-switch shadow suppresses every candidate.
module irq_select
    import irq_gate_pkg::*;
(
    input  logic retire,
    input  logic shadow,
    input  logic step,
    input  logic nmi_ok,
    input  logic intr_ok,
    output sel_e sel
);
    // Pick the highest-priority eligible event.
    always_comb begin
        if (!retire || shadow) sel = SEL_NONE;
        else if (step)         sel = SEL_STEP;
        else if (nmi_ok)       sel = SEL_NMI;
        else if (intr_ok)      sel = SEL_INTR;
        else                   sel = SEL_NONE;
    end
endmodule

// File: rtl/irq_accept_gate.sv
// Top of the interrupt acceptance gating unit. Combines the NMI edge path,
// NMI tracking, enable-flag control and the selector, and registers the
// accept pulses. Assumes decode flags are valid only with retire.
module irq_accept_gate
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             nmi_msg,
    input  logic             intr_req,
    input  logic [VEC_W-1:0] intr_vec,
    input  logic             step_req,
    input  logic             retire,
    input  logic             is_iret,
    input  logic             is_iret_fault,
    input  logic             is_sti,
    input  logic             is_cli,
    input  logic             is_ss_load,
    input  logic             is_int_gate,
    input  logic             is_trap_gate,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  iopl,
    output logic             take_step,
    output logic             take_nmi,
    output logic             take_intr,
    output logic [VEC_W-1:0] acc_vector,
    output logic             gp_fault
);
    logic pin_rise, nmi_arrive, nmi_release, nmi_accept;
    logic pend_eff, blk_eff, nmi_blk_q;
    logic if_eff, if_q, priv_fault;
    logic shadow;
    sel_e sel;

    irq_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .rise(pin_rise)
    );

    // Combine the NMI sources and boundary controls.
    always_comb begin
        nmi_arrive  = pin_rise | nmi_msg;
        nmi_release = retire & (is_iret | is_iret_fault);
        shadow      = retire & is_ss_load;
        nmi_accept  = (sel == SEL_NMI);
    end

    irq_nmi_track u_nmi (
        .clk(clk), .rst_n(rst_n),
        .arrive(nmi_arrive), .release_i(nmi_release), .accept(nmi_accept),
        .pend_eff(pend_eff), .blk_eff(blk_eff), .blk_q(nmi_blk_q)
    );

    irq_if_ctrl u_if (
        .clk(clk), .rst_n(rst_n), .retire(retire),
        .sti(is_sti), .cli(is_cli),
        .int_gate(is_int_gate), .trap_gate(is_trap_gate),
        .cpl(cpl), .iopl(iopl),
        .if_eff(if_eff), .if_q(if_q), .priv_fault(priv_fault)
    );

    irq_select u_sel (
        .retire(retire), .shadow(shadow), .step(step_req),
        .nmi_ok(pend_eff & ~blk_eff), .intr_ok(intr_req & if_eff),
        .sel(sel)
    );

    // Register the winner as one-cycle pulses with its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_step  <= 1'b0;
            take_nmi   <= 1'b0;
            take_intr  <= 1'b0;
            acc_vector <= '0;
            gp_fault   <= 1'b0;
        end else begin
            take_step <= (sel == SEL_STEP);
            take_nmi  <= (sel == SEL_NMI);
            take_intr <= (sel == SEL_INTR);
            gp_fault  <= priv_fault;
            unique case (sel)
                SEL_STEP: acc_vector <= STEP_VEC;
                SEL_NMI:  acc_vector <= NMI_VEC;
                SEL_INTR: acc_vector <= intr_vec;
                default:  acc_vector <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_accept_gate_chk.sv
// Property checker for irq_accept_gate, attached with bind below.
module irq_accept_gate_chk
    import irq_gate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             retire,
    input logic             is_iret,
    input logic             is_iret_fault,
    input logic             is_sti,
    input logic             is_cli,
    input logic             is_ss_load,
    input logic             is_int_gate,
    input logic             is_trap_gate,
    input logic [PL_W-1:0]  cpl,
    input logic [PL_W-1:0]  iopl,
    input logic             take_step,
    input logic             take_nmi,
    input logic             take_intr,
    input logic [VEC_W-1:0] acc_vector,
    input logic             gp_fault,
    input logic             nmi_blk_q,
    input logic             if_q
);
    a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_step, take_nmi, take_intr}));

    a_r2_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (take_step || take_nmi || take_intr) |-> $past(retire));

    a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> (acc_vector == NMI_VEC));

    a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_blk_q && !(retire && (is_iret || is_iret_fault))) |=> !take_nmi);

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        take_intr |-> if_q);

    a_r7_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && (is_sti || is_cli) && (cpl > iopl)) |=> gp_fault);

    a_r7_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && (is_sti || is_cli) && (cpl > iopl) && !is_int_gate) |=> $stable(if_q));

    a_r8_gate_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && is_int_gate && !is_trap_gate) |=> !if_q);

    a_r9_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && is_ss_load) |=> !(take_step || take_nmi || take_intr));
endmodule

bind irq_accept_gate irq_accept_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .retire(retire),
    .is_iret(is_iret), .is_iret_fault(is_iret_fault),
    .is_sti(is_sti), .is_cli(is_cli), .is_ss_load(is_ss_load),
    .is_int_gate(is_int_gate), .is_trap_gate(is_trap_gate),
    .cpl(cpl), .iopl(iopl),
    .take_step(take_step), .take_nmi(take_nmi), .take_intr(take_intr),
    .acc_vector(acc_vector), .gp_fault(gp_fault),
    .nmi_blk_q(nmi_blk_q), .if_q(if_q)
);

// File: tb/tb_irq_accept_gate.sv
`timescale 1ns/100ps
// Self-checking bench: sweeps privilege pairs, event combinations and NMI
// block/merge sequences against a bench model of flag, block and pending.
module tb_irq_accept_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_pin = 0, nmi_msg = 0, intr_req = 0, step_req = 0, retire = 0;
    logic [7:0] intr_vec = 8'h20;
    logic is_iret = 0, is_iret_fault = 0, is_sti = 0, is_cli = 0;
    logic is_ss_load = 0, is_int_gate = 0, is_trap_gate = 0;
    logic [1:0] cpl = 0, iopl = 0;
    logic take_step, take_nmi, take_intr, gp_fault;
    logic [7:0] acc_vector;

    int tests = 0, fails = 0;
    bit done = 0;
    bit m_if = 0, m_blk = 0, m_pend = 0;

    irq_accept_gate dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        retire = 0; nmi_msg = 0; intr_req = 0; step_req = 0;
        is_iret = 0; is_iret_fault = 0; is_sti = 0; is_cli = 0;
        is_ss_load = 0; is_int_gate = 0; is_trap_gate = 0;
    endtask

    // One retire boundary with the currently set flags; checks the pulse
    // and the quiet cycle after it.
    task automatic boundary(string req);
        bit ok, gp, nif, blk, pend, es, en, ei;
        logic [7:0] ev;
        ok   = (cpl <= iopl);
        gp   = (is_sti || is_cli) && !ok;
        nif  = m_if;
        if (is_sti && ok) nif = 1;
        if (is_cli && ok) nif = 0;
        if (is_int_gate && !is_trap_gate) nif = 0;
        blk  = m_blk && !(is_iret || is_iret_fault);
        pend = m_pend || nmi_msg;
        es   = step_req && !is_ss_load;
        en   = !is_ss_load && !step_req && pend && !blk;
        ei   = !is_ss_load && !step_req && !en && intr_req && nif;
        ev   = es ? 8'd1 : en ? 8'd2 : ei ? intr_vec : 8'd0;
        retire = 1;
        @(negedge clk);
        chk({req, " step"}, take_step, es);
        chk({req, " nmi"},  take_nmi,  en);
        chk({req, " intr"}, take_intr, ei);
        chk({req, " vec"},  acc_vector, ev);
        chk({req, " gp"},   gp_fault,  gp);
        m_if = nif; m_pend = pend && !en; m_blk = blk || en;
        clear_in();
        @(negedge clk);
        chk("R2 pulse end", {take_step, take_nmi, take_intr, gp_fault}, 0);
    endtask

    task automatic msg_idle();
        nmi_msg = 1;
        @(negedge clk);
        nmi_msg = 0;
        m_pend = 1;
    endtask

    // Two returns leave NMI unblocked and nothing pending.
    task automatic drain();
        is_iret = 1; boundary("R4 drain");
        is_iret = 1; boundary("R4 drain");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {take_step, take_nmi, take_intr, gp_fault, acc_vector}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle", {take_step, take_nmi, take_intr, gp_fault, acc_vector}, 0);
        intr_req = 1; boundary("R1 flag clear");

        // R7 sweep over privilege pairs; the following request exposes the flag.
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                for (int op = 0; op < 2; op++) begin
                    cpl = c[1:0]; iopl = i[1:0];
                    is_sti = (op == 1); is_cli = (op == 0);
                    boundary("R7 set/clear");
                    intr_req = 1; intr_vec = 8'h40 + 8'(c * 4 + i);
                    boundary("R6 flag probe");
                end

        // R9/R10/R11 sweep over shadow, step, NMI arrival, request, flag.
        for (int p = 0; p < 64; p++) begin
            cpl = 0; iopl = 0;
            drain();
            if (p[4]) is_sti = 1; else is_cli = 1;
            boundary("R11 setup");
            is_ss_load = p[0]; step_req = p[1]; nmi_msg = p[2];
            intr_req = p[3]; intr_vec = 8'h80 + 8'(p);
            is_sti = p[5] && !p[4];
            boundary("R10 combo");
            intr_req = p[3];
            boundary("R9 after shadow");
        end

        // R4/R5 blocking and merge.
        drain();
        msg_idle(); boundary("R3 msg nmi");
        msg_idle(); msg_idle(); msg_idle();
        boundary("R4 blocked");
        boundary("R4 blocked");
        is_iret = 1; boundary("R5 merged release");
        boundary("R5 no second");
        is_iret = 1; boundary("R5 release empty");
        boundary("R5 still none");
        msg_idle(); boundary("R4 nmi");
        msg_idle();
        is_iret_fault = 1; boundary("R4 faulting return");

        // R8 gate entries.
        drain();
        is_sti = 1; boundary("R8 setup");
        is_int_gate = 1; intr_req = 1; boundary("R8 interrupt gate");
        intr_req = 1; boundary("R8 after int gate");
        is_sti = 1; boundary("R8 setup");
        is_trap_gate = 1; intr_req = 1; boundary("R8 trap gate");
        is_int_gate = 1; is_trap_gate = 1; intr_req = 1; boundary("R8 both gates");
        is_sti = 1; is_int_gate = 1; intr_req = 1; boundary("R11 sti with gate");

        // R3 pin path: one edge gives one NMI, a held level gives no more.
        drain();
        is_cli = 1; boundary("R3 mask");
        nmi_pin = 1;
        repeat (4) @(negedge clk);
        m_pend = 1;
        boundary("R3 pin nmi");
        is_iret = 1; boundary("R3 level held");
        boundary("R3 level held");
        nmi_pin = 0;
        repeat (4) @(negedge clk);
        boundary("R3 falling edge");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule